// File: doc/BRIEF.md
# Compare Match Timer Channel

A single up-counting timer channel. Software programs a compare value and a mode bit, then sets a start bit. From then on the counter advances by one on every clock in which the external prescaled tick input is high. When the counter value before an increment equals the compare value, the counter returns to zero and a compare-match flag is raised. If the compare value is all ones at that moment, an overflow flag is raised too.

The mode bit selects what happens after a match. In one-shot mode the start bit clears itself and the counter rests at zero. In free-running mode the counter keeps counting up from zero. Software clears the flags by writing zeros to them through a small word-addressed register port. An interrupt line reports any raised flag while the interrupt enable bit is set.

Top module: `cmt_channel`

## Requirements
- R1: The counter changes only when start (control bit 0) is 1 and `tick` is 1 on the same clock. It then increases by one, or clears on a match. In every other cycle it holds its value, unless software writes it.
- R2: With mode (control bit 1) at 0, a match clears the counter to zero, sets the compare-match flag (control bit 3) and clears the start bit. The counter then stays at zero until start is written to 1 again.
- R3: With mode at 1, a match clears the counter to zero and sets the compare-match flag, and counting resumes. With a steady tick, one match occurs every compare+1 ticks.
- R4: A match while the compare value is 32'hFFFF_FFFF also sets the overflow flag (control bit 4), in either mode. No other event sets the overflow flag.
- R5: A control write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R6: `irq` equals interrupt-enable (control bit 2) AND (compare-match flag OR overflow flag). It follows the flags in the same cycle.
- R7: After a synchronous active-low reset, the counter, start, mode, enable and both flags are 0 and the compare value is 32'hFFFF_FFFF.
- R8: Register map on the 2-bit address: 0 is control (bits 4..0 as above, upper bits read 0), 1 is compare, 2 is the counter (writable), 3 reads 0. Writes take effect on the next clock, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data for rd_addr |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value shows on the counter read word in the cycle after the faulty edge. It also moves the next match, so the flag and `irq` appear on the wrong tick. A wrong start or flag bit shows at once in the control word and, with the enable set, on `irq`. The reference model is compared after every clock, so any divergence is reported within one cycle of its cause.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_LIMIT = 2'd1,
        REG_COUNT = 2'd2,
        REG_NONE  = 2'd3
    } reg_addr_e;

    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_FREE = 1;
    localparam int unsigned BIT_IEN  = 2;
    localparam int unsigned BIT_HIT  = 3;
    localparam int unsigned BIT_WRAP = 4;
    localparam int unsigned CTRL_USED = 5;
endpackage

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         hit
);
    typedef struct packed {
        logic [W-1:0] count;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = run && tick && (st_q.count == limit);
        if (load) begin
            st_d.count = load_val;
        end else if (run && tick) begin
            st_d.count = hit ? '0 : st_q.count + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !load) |=> $stable(count));

    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && (count != limit)) |=> (count == $past(count) + W'(1)));

    assert_clear_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && (count == limit)) |=> (count == '0));
endmodule

// File: rtl/cmt_csr.sv
module cmt_csr
    import cmt_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              hit,
    output logic              run,
    output logic              free,
    output logic              ien,
    output logic              hit_flag,
    output logic              wrap_flag,
    output logic [W-1:0]      limit
);
    typedef struct packed {
        logic         run;
        logic         free;
        logic         ien;
        logic         hit_flag;
        logic         wrap_flag;
        logic [W-1:0] limit;
    } csr_t;

    csr_t st_d, st_q;
    logic wr_ctrl, wr_limit, wrap_evt;

    always_comb begin
        st_d     = st_q;
        wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
        wr_limit = wr_en && (wr_addr == REG_LIMIT);
        wrap_evt = hit && (&st_q.limit);

        if (wr_ctrl) begin
            st_d.run       = wr_data[BIT_RUN];
            st_d.free      = wr_data[BIT_FREE];
            st_d.ien       = wr_data[BIT_IEN];
            st_d.hit_flag  = st_q.hit_flag  & wr_data[BIT_HIT];
            st_d.wrap_flag = st_q.wrap_flag & wr_data[BIT_WRAP];
        end
        if (wr_limit) begin
            st_d.limit = wr_data;
        end

        if (hit) begin
            st_d.hit_flag = 1'b1;
            if (!st_q.free) st_d.run = 1'b0;
        end
        if (wrap_evt) begin
            st_d.wrap_flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.limit <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run       = st_q.run;
    assign free      = st_q.free;
    assign ien       = st_q.ien;
    assign hit_flag  = st_q.hit_flag;
    assign wrap_flag = st_q.wrap_flag;
    assign limit     = st_q.limit;

    assert_oneshot_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !free) |=> !run);

    assert_free_keeps_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && free && !wr_ctrl) |=> run);

    assert_wrap_only_allones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_flag) |-> ($past(hit) && (&$past(limit))));

    assert_flag_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> hit_flag);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq
);
    localparam int unsigned W = 32;

    logic         run, free, ien, hit_flag, wrap_flag, hit, load;
    logic [W-1:0] limit, count;

    assign load = wr_en && (wr_addr == REG_COUNT);

    cmt_csr #(.W(W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hit       (hit),
        .run       (run),
        .free      (free),
        .ien       (ien),
        .hit_flag  (hit_flag),
        .wrap_flag (wrap_flag),
        .limit     (limit)
    );

    cmt_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .limit    (limit),
        .load     (load),
        .load_val (wr_data),
        .count    (count),
        .hit      (hit)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL: begin
                rd_data[BIT_RUN]  = run;
                rd_data[BIT_FREE] = free;
                rd_data[BIT_IEN]  = ien;
                rd_data[BIT_HIT]  = hit_flag;
                rd_data[BIT_WRAP] = wrap_flag;
            end
            REG_LIMIT: rd_data = limit;
            REG_COUNT: rd_data = count;
            default:   rd_data = '0;
        endcase
    end

    assign irq = ien && (hit_flag || wrap_flag);

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);
endmodule

// File: tb/tb_cmt_channel.sv
module tb_cmt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    // reference state
    logic [31:0] m_cnt, m_cmp;
    logic        m_run, m_free, m_ien, m_hit, m_wrap;

    cmt_channel dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_cmp = 32'hFFFF_FFFF;
        m_run = 0; m_free = 0; m_ien = 0; m_hit = 0; m_wrap = 0;
    endtask

    // advance reference by one clock using the inputs present at the edge
    task automatic model_step();
        logic        match;
        logic [31:0] n_cnt, n_cmp;
        logic        n_run, n_free, n_ien, n_hit, n_wrap;
        match = m_run && tick && (m_cnt == m_cmp);
        n_cnt = m_cnt; n_cmp = m_cmp; n_run = m_run; n_free = m_free;
        n_ien = m_ien; n_hit = m_hit; n_wrap = m_wrap;
        if (wr_en && wr_addr == 2'd0) begin
            n_run = wr_data[0]; n_free = wr_data[1]; n_ien = wr_data[2];
            n_hit = m_hit & wr_data[3]; n_wrap = m_wrap & wr_data[4];
        end
        if (wr_en && wr_addr == 2'd1) n_cmp = wr_data;
        if (wr_en && wr_addr == 2'd2) n_cnt = wr_data;
        else if (m_run && tick) n_cnt = match ? 32'd0 : m_cnt + 32'd1;
        if (match) begin
            n_hit = 1'b1;
            if (m_cmp == 32'hFFFF_FFFF) n_wrap = 1'b1;
            if (!m_free) n_run = 1'b0;
        end
        m_cnt = n_cnt; m_cmp = n_cmp; m_run = n_run; m_free = n_free;
        m_ien = n_ien; m_hit = n_hit; m_wrap = n_wrap;
    endtask

    task automatic compare_all(input string phase);
        rd_addr = 2'd0; #1;
        check({"R2/R5 control ", phase}, rd_data, {27'd0, m_wrap, m_hit, m_ien, m_free, m_run});
        rd_addr = 2'd1; #1;
        check({"R8 compare ", phase}, rd_data, m_cmp);
        rd_addr = 2'd2; #1;
        check({"R1/R3 counter ", phase}, rd_data, m_cnt);
        rd_addr = 2'd3; #1;
        check({"R8 unused ", phase}, rd_data, 32'd0);
        check({"R6 irq ", phase}, {31'd0, irq}, {31'd0, m_ien & (m_hit | m_wrap)});
    endtask

    // one clock: apply inputs, clock, update model, compare at negedge
    task automatic cycle(input string phase, input logic t, input logic we,
                         input logic [1:0] wa, input logic [31:0] wd);
        tick = t; wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        compare_all(phase);
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        // R7 reset values
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cycle("R7 reset", 1'b1, 1'b0, 2'd0, 32'd0);
        rst_n = 1'b1;

        // R1: tick without start must not move the counter
        for (int i = 0; i < 4; i++) cycle("R1 idle", 1'b1, 1'b0, 2'd0, 32'd0);

        // R2 one-shot, limit 5, interrupt enabled
        cycle("R8 set limit", 1'b0, 1'b1, 2'd1, 32'd5);
        cycle("R2 start", 1'b0, 1'b1, 2'd0, 32'h5);
        for (int i = 0; i < 16; i++) cycle("R2 oneshot", 1'b1, 1'b0, 2'd0, 32'd0);
        // R5 writing 1 to flag bits keeps them
        cycle("R5 keep", 1'b0, 1'b1, 2'd0, 32'h1C);
        // R5 writing 0 clears them
        cycle("R5 clear", 1'b0, 1'b1, 2'd0, 32'h4);

        // R3 free-running, limit 3, gapped tick, repeated clear writes
        cycle("R8 set limit", 1'b0, 1'b1, 2'd1, 32'd3);
        cycle("R3 start", 1'b0, 1'b1, 2'd0, 32'h7);
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 4) cycle("R5 clear while run", i[0], 1'b1, 2'd0, 32'h7);
            else            cycle("R3 free", i[0], 1'b0, 2'd0, 32'd0);
        end
        // R1 tick held low keeps count
        for (int i = 0; i < 4; i++) cycle("R1 no tick", 1'b0, 1'b0, 2'd0, 32'd0);

        // R4 overflow with all-ones limit
        cycle("R4 stop", 1'b0, 1'b1, 2'd0, 32'h4);
        cycle("R4 load", 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFC);
        cycle("R4 limit", 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        cycle("R4 start", 1'b0, 1'b1, 2'd0, 32'h7);
        for (int i = 0; i < 10; i++) cycle("R4 wrap", 1'b1, 1'b0, 2'd0, 32'd0);
        // R4 one-shot overflow, irq disabled (R6)
        cycle("R4 load", 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFE);
        cycle("R6 start noirq", 1'b0, 1'b1, 2'd0, 32'h1);
        for (int i = 0; i < 6; i++) cycle("R4 oneshot wrap", 1'b1, 1'b0, 2'd0, 32'd0);

        // R7 reset again mid-state
        rst_n = 1'b0;
        cycle("R7 reset", 1'b1, 1'b0, 2'd0, 32'd0);
        rst_n = 1'b1;
        cycle("R7 after reset", 1'b1, 1'b0, 2'd0, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule